// File: doc/BRIEF.md
# PLL Standby and Lock Controller

This block sits beside one PLL channel and gives software a small register window for it. Software takes the PLL out of standby by writing a release bit, together with a per-bit write enable in the same word. A lock timer stands in for the analog loop. After a release, the lock flag rises once a fixed, parameterised number of reference cycles has passed. A monitor register shows the release state and the lock flag, and the PLL counts as running only while both are set.

The block also holds the divider settings: a signed fractional term, an integer multiplier, a pre-divider and a power-of-two post-divider exponent. From these and a reference-frequency word it computes the output frequency word continuously. The register port is a single-cycle bus. A write lands on the clock edge where select and write are both high. Read data is combinational from the address.

The lock delay is a parameter. Its default of 1000 cycles is far below the roughly 2 ms that software waits for lock.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After reset, every register reads 0: standby at 0x0, config-1 at 0x4, config-2 at 0x8 and monitor at 0x10. The outputs `pll_rst_rel`, `pll_locked` and `pll_running` are 0.
- R2: A write to 0x0 with bit 16 set loads bit 0 into the release state on that edge. Standby bit 0 reads back the release state.
- R3: A write to 0x0 with bit 16 clear leaves the release state unchanged.
- R4: After the edge that sets the release state, the lock flag stays 0 for LOCK_CYCLES cycles and is 1 after the LOCK_CYCLES-th following edge.
- R5: Monitor bit 0 reads the release state and bit 4 reads the lock flag; all other monitor bits read 0. `pll_running` is 1 only while both are 1.
- R6: A write that clears the release state clears the release and lock flags on the same edge.
- R7: Config-1 is a full 32-bit read/write register. Bits 31:16 hold the signed fraction K, bits 15:6 the multiplier M, and bits 5:0 the pre-divider P.
- R8: Config-2 keeps only bits 2:0, the exponent S, and its other bits read 0. Writes to the monitor have no effect, and unmapped offsets such as 0xC and 0x14 read 0.
- R9: `out_rate` equals floor(ref × ((M·65536)+K) / 2^(16+S)), then divided by P and rounded to the nearest integer, with halves rounding up.
- R10: A P field of 0 is treated as 1 in the rate computation.
- R11: If (M·65536)+K is negative, the multiplier term is taken as 0, so `out_rate` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | ADDR_W | Byte offset within the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ref_hz | input | REF_W | Reference frequency word |
| pll_rst_rel | output | 1 | Release from standby (to the PLL) |
| pll_locked | output | 1 | Lock flag |
| pll_running | output | 1 | Released and locked |
| out_rate | output | REF_W+11 | Computed output frequency word |

## Verification
On every cycle, the assertions check the write-enable rule on the standby register in both directions. They also check that the lock flag is never set without the release, that lock never rises on the release edge itself, and that a fall of the release drops lock and running together. The exact lock delay, the register readback and masking, and the rate arithmetic (rounding, P of zero, a negative multiplier) can only be shown by the bench's scenarios. For the rate, the bench sweeps every post-divider exponent against a set of pre-divider, multiplier, fraction and reference values.

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl #(
  parameter int REF_W       = 32,
  parameter int LOCK_CYCLES = 1000,
  parameter int ADDR_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [REF_W-1:0]  ref_hz,
  output logic              pll_rst_rel,
  output logic              pll_locked,
  output logic              pll_running,
  output logic [REF_W+10:0] out_rate
);
  localparam int CNT_W  = $clog2(LOCK_CYCLES + 1);
  localparam int RATE_W = REF_W + 11;
  localparam int PROD_W = REF_W + 26;
  localparam logic [ADDR_W-1:0] OFF_STBY = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CFG1 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_CFG2 = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_MON  = ADDR_W'(16);

  logic             rel_q, lock_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      cfg1_q;
  logic [2:0]       sexp_q;

  wire wr_en   = bus_sel & bus_we;
  wire stby_wr = wr_en && (bus_addr == OFF_STBY) && bus_wdata[16];
  wire rel_d   = stby_wr ? bus_wdata[0] : rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= 1'b0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      rel_q <= rel_d;
      if (!rel_d) begin
        lock_q <= 1'b0;
        cnt_q  <= '0;
      end else if (rel_q && !lock_q) begin
        if (cnt_q == CNT_W'(LOCK_CYCLES - 1)) lock_q <= 1'b1;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= '0;
      sexp_q <= '0;
    end else if (wr_en) begin
      if (bus_addr == OFF_CFG1) cfg1_q <= bus_wdata;
      if (bus_addr == OFF_CFG2) sexp_q <= bus_wdata[2:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_STBY: bus_rdata[0]   = rel_q;
      OFF_CFG1: bus_rdata      = cfg1_q;
      OFF_CFG2: bus_rdata[2:0] = sexp_q;
      OFF_MON:  bus_rdata      = {27'd0, lock_q, 3'd0, rel_q};
      default:  bus_rdata      = '0;
    endcase
  end

  assign pll_rst_rel = rel_q;
  assign pll_locked  = lock_q;
  assign pll_running = rel_q & lock_q;

  wire [15:0] frac_k = cfg1_q[31:16];
  wire [9:0]  mul_m  = cfg1_q[15:6];
  wire [5:0]  pre_p  = cfg1_q[5:0];

  wire [27:0] msum = {2'b00, mul_m, 16'd0} + {{12{frac_k[15]}}, frac_k};
  wire [25:0] mult = msum[27] ? 26'd0 : msum[25:0];
  wire [5:0]  pdiv = (pre_p == 6'd0) ? 6'd1 : pre_p;

  wire [PROD_W-1:0] prod    = PROD_W'(ref_hz) * PROD_W'(mult);
  wire [PROD_W-1:0] shifted = prod >> (5'd16 + {2'b00, sexp_q});
  wire [PROD_W-1:0] rounded = (shifted + PROD_W'(pdiv >> 1)) / PROD_W'(pdiv);

  assign out_rate = RATE_W'(rounded);
endmodule

module pll_lock_ctrl_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              pll_rst_rel,
  input logic              pll_locked,
  input logic              pll_running
);
  wire stby_access = bus_sel && bus_we && (bus_addr == '0);

  // R2
  stby_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_access && bus_wdata[16]) |=> (pll_rst_rel == $past(bus_wdata[0])));

  // R3
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_access && !bus_wdata[16]) |=> $stable(pll_rst_rel));

  // R4
  lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_locked) |-> $past(pll_rst_rel));

  // R5
  lock_needs_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_locked |-> pll_rst_rel);

  // R6
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst_rel) |-> (!pll_locked && !pll_running));
endmodule

bind pll_lock_ctrl pll_lock_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pll_rst_rel(pll_rst_rel),
  .pll_locked(pll_locked), .pll_running(pll_running)
);

// File: tb/pll_lock_ctrl_tb.sv
module pll_lock_ctrl_tb;
  localparam int LC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] ref_hz = 32'd24000000;
  logic        pll_rst_rel, pll_locked, pll_running;
  logic [42:0] out_rate;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pll_lock_ctrl #(.REF_W(32), .LOCK_CYCLES(LC), .ADDR_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ref_hz(ref_hz), .pll_rst_rel(pll_rst_rel), .pll_locked(pll_locked),
    .pll_running(pll_running), .out_rate(out_rate)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [42:0] exp_rate(input logic [31:0] r, input logic [9:0] m,
                                           input logic [15:0] k, input logic [2:0] s,
                                           input logic [5:0] p);
    longint mm;
    logic [63:0] t;
    longint pp;
    mm = (longint'(m) * 65536) + longint'($signed(k));
    if (mm < 0) mm = 0;
    t = (64'(r) * 64'(mm)) >> (16 + int'(s));
    pp = (p == 0) ? 1 : longint'(p);
    t = (t + 64'(pp / 2)) / 64'(pp);
    return t[42:0];
  endfunction

  task automatic lock_run(input string tag);
    chk({tag, " R4 unlocked right after release"}, 64'(pll_locked), 64'd0);
    for (int i = 1; i <= LC; i++) begin
      @(negedge clk); #1;
      chk({tag, " R4 lock delay"}, 64'(pll_locked), (i >= LC) ? 64'd1 : 64'd0);
      chk({tag, " R5 running"}, 64'(pll_running), (i >= LC) ? 64'd1 : 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [9:0]  ml[4] = '{10'd0, 10'd1, 10'd100, 10'd1023};
    logic [15:0] kl[3] = '{16'h0000, 16'h7FFF, 16'h8000};
    logic [5:0]  pl[6] = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd5, 6'd63};
    logic [31:0] rl[3] = '{32'd24000000, 32'd1, 32'hFFFFFFFF};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    rd(5'h00, v); chk("R1 standby", 64'(v), 0);
    rd(5'h04, v); chk("R1 cfg1", 64'(v), 0);
    rd(5'h08, v); chk("R1 cfg2", 64'(v), 0);
    rd(5'h10, v); chk("R1 monitor", 64'(v), 0);
    chk("R1 outputs", {61'd0, pll_rst_rel, pll_locked, pll_running}, 0);

    // R3: release bit without its enable
    wr(5'h00, 32'h0000_0001);
    rd(5'h00, v); chk("R3 no enable", 64'(v), 0);
    rd(5'h10, v); chk("R3 monitor", 64'(v), 0);

    // R2, R4, R5
    wr(5'h00, 32'h0001_0001);
    rd(5'h00, v); chk("R2 release readback", 64'(v), 1);
    rd(5'h10, v); chk("R5 monitor released", 64'(v), 64'h1);
    lock_run("first");
    rd(5'h10, v); chk("R5 monitor locked", 64'(v), 64'h11);

    // R3: clear attempt without enable
    wr(5'h00, 32'h0000_0000);
    rd(5'h10, v); chk("R3 hold while locked", 64'(v), 64'h11);

    // R6
    wr(5'h00, 32'h0001_0000);
    chk("R6 flags cleared", {62'd0, pll_rst_rel, pll_locked}, 0);
    rd(5'h10, v); chk("R6 monitor", 64'(v), 0);

    wr(5'h00, 32'hFFFF_FFFF);
    lock_run("second");

    // R8
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R8 cfg2 mask", 64'(v), 7);
    wr(5'h10, 32'h0000_0000);
    rd(5'h10, v); chk("R8 monitor read-only", 64'(v), 64'h11);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R8 unmapped 0xC", 64'(v), 0);
    rd(5'h14, v); chk("R8 unmapped 0x14", 64'(v), 0);

    // R7
    wr(5'h04, 32'hA5C3_5A3C);
    rd(5'h04, v); chk("R7 cfg1 readback", 64'(v), 64'hA5C3_5A3C);

    // R9, R10, R11 sweep
    for (int ri = 0; ri < 3; ri++) begin
      ref_hz = rl[ri];
      for (int mi = 0; mi < 4; mi++)
        for (int ki = 0; ki < 3; ki++)
          for (int pi = 0; pi < 6; pi++) begin
            wr(5'h04, {kl[ki], ml[mi], pl[pi]});
            for (int s = 0; s < 8; s++) begin
              wr(5'h08, 32'(s));
              chk((pl[pi] == 0) ? "R10 rate P=0" :
                  (ml[mi] == 0 && kl[ki][15]) ? "R11 rate negative" : "R9 rate",
                  64'(out_rate), 64'(exp_rate(rl[ri], ml[mi], kl[ki], 3'(s), pl[pi])));
            end
          end
    end

    // R11 explicit
    wr(5'h04, {16'hFFFF, 10'd0, 6'd1});
    chk("R11 negative clamp", 64'(out_rate), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule